// File: doc/BRIEF.md
# Cascaded Pole-Zero Stream Filter

This block applies a rational transfer function, a numerator polynomial over a denominator polynomial in z^-1, to a stream of signed 8-bit fractional samples (one sign bit, seven fraction bits). It is built as a chain of identical sections. Each section is a direct-form pole-zero stage of order `SECT_ORD`. A section sees only the section before it and the section after it, so the overall response is the product of the section responses. A long filter therefore becomes a series of short stages. The largest order the chain supports is 64, which means `N_SECT * SECT_ORD` must not exceed 64.

Coefficients are loaded through a small write port before a run starts. A write selects the section, chooses the numerator or denominator set, and gives the tap index. The leading denominator term is fixed at one, so the loaded values are already normalised. When every denominator value is zero, the same hardware acts as a plain FIR filter.

Samples enter and leave through valid/ready handshakes. A run may be any length, because the block keeps no sample count. Each section holds a two-state machine, EMPTY and FULL, with these transitions:
- LOAD goes from EMPTY to FULL when a sample is accepted.
- REFILL stays in FULL when the held result is taken and a new sample is accepted in the same cycle.
- DRAIN goes from FULL to EMPTY when the result is taken and nothing new arrives.
- FLUSH returns a section from any state to EMPTY when clear is asserted.

Top module: `pzf_cascade`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every coefficient is zero, and every section is an identity stage that passes its input unchanged.
- R2: An active section computes y[n] = sum over k=0..K of b[k]·x[n-k], minus the sum over k=1..K of a[k]·y[n-k], where K = `SECT_ORD`. The leading denominator term is implicitly 1.0, and a write to denominator index 0 leaves the response unchanged.
- R3: Products are summed at full precision. The sum is then rounded to the nearest 2^-7, with ties going toward plus infinity, and saturated to the range -128..127. For example, with b0 = 64 the inputs 3 and -3 give 2 and -1.
- R4: With all a[k] = 0, a section is an FIR filter. With b = {64, 32, 0} it maps the inputs 0, 2, 4, -4, 127, -128, 1, -1 to 0, 1, 3, -1, 63, -32, -31, 0.
- R5: The output stream equals the input stream passed through section 0, then section 1, and so on through section `N_SECT-1`, in order. Each section has its own state.
- R6: A write (`cfg_we`=1) addresses section `cfg_sect`. It targets the numerator set when `cfg_den`=0 and the denominator set when `cfg_den`=1, at tap `cfg_idx`. A write with `cfg_idx` > `SECT_ORD` has no effect. Any other write to a section ends its identity mode, and taps that were never written stay zero.
- R7: With `out_ready` held high, a sample accepted at one clock edge appears on `out_valid` exactly `N_SECT` edges later. The chain accepts one sample every clock.
- R8: While `out_ready` is 0, `out_valid` stays 1 and `out_data` stays stable. No sample is lost or duplicated. `in_ready` is 1 whenever `out_ready` is 1. With all sections full and `out_ready` at 0, `in_ready` is 0.
- R9: `clr` zeroes all delay state and empties all sections, so `out_valid` is 0 on the next cycle. Loaded coefficients are kept, and a sample offered during `clr` is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of delay state and pipeline |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sect | input | SEL_W | Section addressed by the write |
| cfg_den | input | 1 | 0: numerator tap, 1: denominator tap |
| cfg_idx | input | IDX_W | Tap index within the section |
| cfg_data | input | DATA_W | Coefficient value, Q1.7 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Chain can accept a sample |
| in_data | input | DATA_W | Input sample, Q1.7 |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can take the sample |
| out_data | output | DATA_W | Output sample, Q1.7 |

## Verification
The bench drives the chain with several kinds of input, and each kind separates a different class of error:
- Sections left in identity mode with a single sample show the per-stage latency.
- A mixed-sign vector through a two-tap FIR catches tap order and the floor direction of the rounding.
- Paired odd inputs at one half gain pin down how ties are broken.
- Full-scale runs of one sign push the sum past the range and expose a missing or one-sided clamp.
- An impulse into a section with a negative a1 shows whether feedback is subtracted and whether the output is the value fed back.
- A ramp through three differently loaded sections, under irregular `out_ready`, tests ordering between sections and loss-free stalling.
- Repeating the impulse run after `clr` shows that the delay state is cleared while the coefficients survive.

// File: rtl/pzf_pkg.sv
package pzf_pkg;

    typedef enum logic [0:0] {
        SECT_EMPTY = 1'b0,
        SECT_FULL  = 1'b1
    } sect_state_e;

endpackage

// File: rtl/pzf_coef_bank.sv
module pzf_coef_bank #(
    parameter int DATA_W  = 8,
    parameter int ORD     = 2,
    parameter int SEL_W   = 2,
    parameter int IDX_W   = 2,
    parameter int SECT_ID = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_sect,
    input  logic                        cfg_den,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic [DATA_W-1:0]           cfg_data,
    output logic [ORD:0][DATA_W-1:0]    num_o,
    output logic [ORD:1][DATA_W-1:0]    den_o,
    output logic                        ident_o
);

    logic [ORD:0][DATA_W-1:0] num_q;
    logic [ORD:1][DATA_W-1:0] den_q;
    logic                     ident_q;
    logic                     hit;
    logic                     idx_ok;

    assign hit    = cfg_we && (cfg_sect == SEL_W'(SECT_ID));
    assign idx_ok = (int'(cfg_idx) <= ORD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q   <= '0;
            den_q   <= '0;
            ident_q <= 1'b1;
        end else if (hit && idx_ok) begin
            ident_q <= 1'b0;
            for (int k = 0; k <= ORD; k++) begin
                if (!cfg_den && (cfg_idx == IDX_W'(k))) begin
                    num_q[k] <= cfg_data;
                end
            end
            for (int k = 1; k <= ORD; k++) begin
                if (cfg_den && (cfg_idx == IDX_W'(k))) begin
                    den_q[k] <= cfg_data;
                end
            end
        end
    end

    assign num_o   = num_q;
    assign den_o   = den_q;
    assign ident_o = ident_q;

endmodule

// File: rtl/pzf_section.sv
module pzf_section
    import pzf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ORD    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic [ORD:0][DATA_W-1:0]    num_i,
    input  logic [ORD:1][DATA_W-1:0]    den_i,
    input  logic                        ident_i,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [DATA_W-1:0]           in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [DATA_W-1:0]           out_data
);

    localparam int FRAC   = DATA_W - 1;
    localparam int PROD_W = 2 * DATA_W;
    localparam int TERMS  = 2 * ORD + 1;
    localparam int ACC_W  = PROD_W + $clog2(TERMS + 1);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (FRAC - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'(2 ** (DATA_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

    sect_state_e st_q, st_d;

    logic [ORD:1][DATA_W-1:0]  xd_q;
    logic [ORD:1][DATA_W-1:0]  yd_q;
    logic [DATA_W-1:0]         y_q;
    logic signed [PROD_W-1:0]  prod;
    logic signed [ACC_W-1:0]   acc;
    logic signed [ACC_W-1:0]   rnd;
    logic [DATA_W-1:0]         y_calc;
    logic [DATA_W-1:0]         y_next;
    logic                      take;
    logic                      give;

    assign in_ready  = (st_q == SECT_EMPTY) || out_ready;
    assign take      = in_valid && in_ready;
    assign give      = (st_q == SECT_FULL) && out_ready;
    assign out_valid = (st_q == SECT_FULL);
    assign out_data  = y_q;

    always_comb begin
        acc  = '0;
        prod = $signed(num_i[0]) * $signed(in_data);
        acc  = acc + ACC_W'(prod);
        for (int k = 1; k <= ORD; k++) begin
            prod = $signed(num_i[k]) * $signed(xd_q[k]);
            acc  = acc + ACC_W'(prod);
            prod = $signed(den_i[k]) * $signed(yd_q[k]);
            acc  = acc - ACC_W'(prod);
        end
        rnd = (acc + HALF) >>> FRAC;
        if (rnd > MAXV) begin
            y_calc = MAXV[DATA_W-1:0];
        end else if (rnd < MINV) begin
            y_calc = MINV[DATA_W-1:0];
        end else begin
            y_calc = rnd[DATA_W-1:0];
        end
        y_next = ident_i ? in_data : y_calc;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SECT_EMPTY: if (take) st_d = SECT_FULL;
            SECT_FULL:  if (give && !take) st_d = SECT_EMPTY;
            default:    st_d = SECT_EMPTY;
        endcase
        if (clr) st_d = SECT_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SECT_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            xd_q <= '0;
            yd_q <= '0;
            y_q  <= '0;
        end else if (take) begin
            y_q     <= y_next;
            xd_q[1] <= in_data;
            yd_q[1] <= y_next;
            for (int k = 2; k <= ORD; k++) begin
                xd_q[k] <= xd_q[k-1];
                yd_q[k] <= yd_q[k-1];
            end
        end
    end

endmodule

// File: rtl/pzf_cascade.sv
module pzf_cascade #(
    parameter int DATA_W   = 8,
    parameter int N_SECT   = 4,
    parameter int SECT_ORD = 2,
    parameter int SEL_W    = (N_SECT > 1) ? $clog2(N_SECT) : 1,
    parameter int IDX_W    = $clog2(SECT_ORD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sect,
    input  logic              cfg_den,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    logic [N_SECT:0]             lnk_vld;
    logic [N_SECT:0]             lnk_rdy;
    logic [N_SECT:0][DATA_W-1:0] lnk_dat;

    assign lnk_vld[0]      = in_valid;
    assign lnk_dat[0]      = in_data;
    assign in_ready        = lnk_rdy[0];
    assign out_valid       = lnk_vld[N_SECT];
    assign out_data        = lnk_dat[N_SECT];
    assign lnk_rdy[N_SECT] = out_ready;

    for (genvar s = 0; s < N_SECT; s++) begin : g_stage
        logic [SECT_ORD:0][DATA_W-1:0] num;
        logic [SECT_ORD:1][DATA_W-1:0] den;
        logic                          ident;

        pzf_coef_bank #(
            .DATA_W (DATA_W),
            .ORD    (SECT_ORD),
            .SEL_W  (SEL_W),
            .IDX_W  (IDX_W),
            .SECT_ID(s)
        ) u_coef (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we),
            .cfg_sect(cfg_sect),
            .cfg_den (cfg_den),
            .cfg_idx (cfg_idx),
            .cfg_data(cfg_data),
            .num_o   (num),
            .den_o   (den),
            .ident_o (ident)
        );

        pzf_section #(
            .DATA_W(DATA_W),
            .ORD   (SECT_ORD)
        ) u_sect (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .num_i    (num),
            .den_i    (den),
            .ident_i  (ident),
            .in_valid (lnk_vld[s]),
            .in_ready (lnk_rdy[s]),
            .in_data  (lnk_dat[s]),
            .out_valid(lnk_vld[s+1]),
            .out_ready(lnk_rdy[s+1]),
            .out_data (lnk_dat[s+1])
        );
    end

endmodule

// File: rtl/pzf_cascade_chk.sv
module pzf_cascade_chk #(
    parameter int DATA_W = 8,
    parameter int N_SECT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);

    localparam int OCC_W = $clog2(N_SECT + 1) + 1;

    logic [OCC_W-1:0] occ;
    logic             in_fire;
    logic             out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) occ <= '0;
        else               occ <= occ + OCC_W'(in_fire) - OCC_W'(out_fire);
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data))); // R8
    AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready); // R8
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !out_valid); // R9
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (occ != '0)); // R8
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= N_SECT); // R7
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(occ) == N_SECT) && !out_ready) |-> !in_ready); // R8

endmodule

bind pzf_cascade pzf_cascade_chk #(.DATA_W(DATA_W), .N_SECT(N_SECT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/tb_pzf_cascade.sv
module tb_pzf_cascade;

    localparam int NS = 4;
    localparam int KO = 2;

    // table: input sample, expected output for b = {64,32,0}, a = 0
    localparam int TBL_N = 8;
    localparam int TBL [TBL_N][2] = '{
        '{0, 0}, '{2, 1}, '{4, 3}, '{-4, -1},
        '{127, 63}, '{-128, -32}, '{1, -31}, '{-1, 0}
    };

    logic       clk = 1'b0;
    logic       rst_n, clr, cfg_we, cfg_den;
    logic [1:0] cfg_sect, cfg_idx;
    logic [7:0] cfg_data, in_data, out_data;
    logic       in_valid, in_ready, out_valid, out_ready;

    int checks = 0;
    int failures = 0;
    int src [256];
    int got [256];
    int first_run [16];

    int mb [NS][KO+1];
    int ma [NS][KO+1];
    bit mid [NS];
    int mx [NS][KO+1];
    int my [NS][KO+1];

    always #5 clk = ~clk;

    pzf_cascade dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .cfg_we(cfg_we), .cfg_sect(cfg_sect), .cfg_den(cfg_den),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sect_step(input int s, input int x);
        int acc, r, y;
        if (mid[s]) begin
            y = x;
        end else begin
            acc = mb[s][0] * x;
            for (int k = 1; k <= KO; k++) acc = acc + mb[s][k] * mx[s][k] - ma[s][k] * my[s][k];
            r = (acc + 64) >>> 7;
            y = (r > 127) ? 127 : ((r < -128) ? -128 : r);
        end
        for (int k = KO; k >= 2; k--) begin
            mx[s][k] = mx[s][k-1];
            my[s][k] = my[s][k-1];
        end
        mx[s][1] = x;
        my[s][1] = y;
        return y;
    endfunction

    function automatic int model(input int x);
        int v = x;
        for (int s = 0; s < NS; s++) v = sect_step(s, v);
        return v;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < NS; s++)
            for (int k = 0; k <= KO; k++) begin
                mx[s][k] = 0;
                my[s][k] = 0;
            end
    endtask

    task automatic cfg_wr(input int s, input bit den, input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sect = 2'(s); cfg_den = den; cfg_idx = 2'(idx); cfg_data = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx <= KO) begin
            mid[s] = 1'b0;
            if (!den) mb[s][idx] = val;
            else if (idx != 0) ma[s][idx] = val;
        end
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        chk("R9 clr empties", int'(out_valid), 0);
    endtask

    task automatic stream(input int n, input int rmode, output int cyc);
        int sent = 0;
        int rcv = 0;
        cyc = 0;
        while (rcv < n && cyc < 5000) begin
            @(negedge clk);
            in_valid  = (sent < n);
            in_data   = (sent < n) ? 8'(src[sent]) : 8'h00;
            out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
            #1;
            if (in_valid && in_ready) sent++;
            if (out_valid && out_ready) begin
                got[rcv] = int'($signed(out_data));
                rcv++;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        chk("R8 sample count", rcv, n);
    endtask

    task automatic check_model(input string req, input int n);
        for (int i = 0; i < n; i++) chk(req, got[i], model(src[i]));
    endtask

    initial begin
        int cyc, lat, held, acc_n;
        rst_n = 1'b0; clr = 1'b0; cfg_we = 1'b0; cfg_den = 1'b0;
        cfg_sect = '0; cfg_idx = '0; cfg_data = '0;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        for (int s = 0; s < NS; s++) begin
            mid[s] = 1'b1;
            for (int k = 0; k <= KO; k++) begin mb[s][k] = 0; ma[s][k] = 0; end
        end
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset in_ready", int'(in_ready), 1);

        // R7 latency through identity sections, R1 identity value
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b1; in_data = 8'd37;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
        chk("R7 latency", lat, NS);
        chk("R1 identity data", int'($signed(out_data)), 37);
        do_clr();

        // R7 one sample per clock
        for (int i = 0; i < 8; i++) src[i] = i * 9 - 30;
        stream(8, 0, cyc);
        chk("R7 throughput cycles", cyc, 8 + NS);
        for (int i = 0; i < 8; i++) chk("R1 identity stream", got[i], src[i]);

        // R4 FIR table, walked by one loop
        cfg_wr(0, 1'b0, 0, 64);
        cfg_wr(0, 1'b0, 1, 32);
        do_clr();
        for (int i = 0; i < TBL_N; i++) src[i] = TBL[i][0];
        stream(TBL_N, 0, cyc);
        for (int i = 0; i < TBL_N; i++) chk("R4 fir table", got[i], TBL[i][1]);

        // R3 rounding ties toward plus infinity
        cfg_wr(0, 1'b0, 1, 0);
        do_clr();
        src[0] = 1; src[1] = -1; src[2] = 3; src[3] = -3; src[4] = 5;
        stream(5, 0, cyc);
        chk("R3 round 0.5", got[0], 1);
        chk("R3 round -0.5", got[1], 0);
        chk("R3 round 1.5", got[2], 2);
        chk("R3 round -1.5", got[3], -1);
        chk("R3 round 2.5", got[4], 3);

        // R3 saturation
        cfg_wr(0, 1'b0, 0, 127);
        cfg_wr(0, 1'b0, 1, 127);
        cfg_wr(0, 1'b0, 2, 127);
        do_clr();
        src[0] = 127; src[1] = 127; src[2] = 127; src[3] = -128; src[4] = -128; src[5] = -128;
        stream(6, 0, cyc);
        chk("R3 sat a", got[0], 126);
        chk("R3 sat b", got[1], 127);
        chk("R3 sat c", got[2], 127);
        chk("R3 sat d", got[3], 125);
        chk("R3 sat e", got[4], -128);
        chk("R3 sat f", got[5], -128);

        // R2 feedback, leading denominator ignored; R6 out-of-range index ignored
        cfg_wr(0, 1'b0, 0, 64);
        cfg_wr(0, 1'b0, 1, 0);
        cfg_wr(0, 1'b0, 2, 0);
        cfg_wr(0, 1'b1, 1, -64);
        cfg_wr(0, 1'b1, 0, 100);
        cfg_wr(2, 1'b0, 3, 90);
        do_clr();
        src[0] = 127;
        for (int i = 1; i < 10; i++) src[i] = 0;
        stream(10, 0, cyc);
        chk("R2 impulse y0", got[0], 64);
        chk("R2 impulse y1", got[1], 32);
        for (int i = 0; i < 10; i++) first_run[i] = got[i];
        check_model("R2 feedback model", 10);

        // R9 clear keeps coefficients, zeroes state
        do_clr();
        stream(10, 0, cyc);
        for (int i = 0; i < 10; i++) chk("R9 rerun after clr", got[i], first_run[i]);
        model_clear();
        for (int i = 0; i < 10; i++) void'(model(src[i]));

        // R6 unwritten taps stay zero once a section is addressed
        cfg_wr(3, 1'b1, 1, 0);
        do_clr();
        for (int i = 0; i < 4; i++) src[i] = 50 + i;
        stream(4, 0, cyc);
        for (int i = 0; i < 4; i++) chk("R6 zero taps", got[i], 0);
        cfg_wr(3, 1'b0, 0, 120);

        // R5 cascade order under R8 back-pressure
        cfg_wr(1, 1'b0, 0, 40);
        cfg_wr(1, 1'b0, 1, 40);
        cfg_wr(1, 1'b0, 2, -20);
        cfg_wr(2, 1'b0, 0, 90);
        cfg_wr(2, 1'b1, 1, 30);
        cfg_wr(2, 1'b1, 2, -25);
        do_clr();
        for (int i = 0; i < 24; i++) src[i] = ((i * 37) % 200) - 100;
        stream(24, 1, cyc);
        check_model("R5 cascade model", 24);

        // R8 full stall: hold, stable data, no loss
        do_clr();
        @(negedge clk);
        out_ready = 1'b0;
        acc_n = 0;
        for (int i = 0; i < NS + 3; i++) begin
            in_valid = 1'b1;
            in_data = 8'(acc_n * 21 - 40);
            #1;
            if (in_ready) begin src[acc_n] = acc_n * 21 - 40; acc_n++; end
            @(negedge clk);
        end
        in_valid = 1'b0;
        #1;
        chk("R8 accepted while stalled", acc_n, NS);
        chk("R8 in_ready low when full", int'(in_ready), 0);
        held = int'(out_data);
        repeat (4) @(negedge clk);
        chk("R8 valid held", int'(out_valid), 1);
        chk("R8 data stable", int'(out_data), held);
        out_ready = 1'b1;
        for (int i = 0; i < NS; i++) begin
            #1;
            got[i] = out_valid ? int'($signed(out_data)) : 999;
            @(negedge clk);
        end
        check_model("R8 drain order", NS);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule